// File: doc/BRIEF.md
# Video Blanking, Clipping and Edge-Shaping Stage

This stage takes a luma stream and a multiplexed colour-difference stream, one sample of each per clock, after colour-space conversion. It limits every sample to a programmable legal range. Outside the active picture it puts a programmable blanking level on both channels, and in the sync region it puts programmed sync words on them. Where the picture starts and ends it fades between blanking and video along a raised-cosine curve instead of switching hard. The active-window and sync-region flags come from an external timing generator.

Each channel keeps a position counter that steps toward full video while the active flag is high and back toward blanking while it is low. A cosine weight is taken from the counter's position relative to the programmed edge length, and that weight blends the blanking level with the clipped sample. The colour-difference channel carries two components per pixel pair, so its counter moves once per pair and its edge length is counted in pairs. A flat test field can take the place of the incoming video. Blanking, sync and edge shaping still apply to it.

Top module: `vid_blank_clip`

## Requirements
- R1: Each channel clips its sample to its own limits. A value below the low limit becomes the low limit. The result is then capped at the high limit, so the high limit wins when the low limit exceeds it.
- R2: Once a channel's position counter has fallen to 0 with the active flag low and sync low, the channel outputs its blanking level.
- R3: While the sync flag is high, each channel outputs its sync word, overriding video, blanking, pattern and transitions. The position counters keep following the active flag during sync.
- R4: The output appears one clock after its inputs. It is blank + floor(((clipped - blank) * w + 64) / 128), where w = T[floor(pos * 16 / L)], L is the effective edge length, pos (0..L) is the channel's position after this sample, and T[0..16] = 0,1,5,11,19,28,40,52,64,76,88,100,109,117,123,127,128.
- R5: The luma position counter updates on every sample. It goes up by one (saturating at L) when the active flag is high and down by one (saturating at 0) when it is low. A luma length field of 0..16 is used as given, and any larger value acts as 16.
- R6: The chroma position counter updates only on the first sample of each pair, counting samples from the end of reset. The second sample of the pair reuses the first sample's weight. A chroma length of 0..8 is used as given, and any larger value acts as 8.
- R7: With an effective length of 0, the weight is 128 on every sample where the active flag is high and 0 on every sample where it is low, so the output switches abruptly.
- R8: Clipping happens before blending. Whenever sync is low and low limit <= high limit, the output lies between min(blank, low) and max(blank, high).
- R9: When the pattern enable is high, each channel's pattern value replaces the incoming sample before clipping. Blanking, sync words and transitions are unchanged.
- R10: While reset is high, both outputs are 0 and both counters are 0. The first sample after reset is the first of a chroma pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| luma_in | input | 8 | Luma sample |
| chroma_in | input | 8 | Multiplexed colour-difference sample |
| active_in | input | 1 | High inside the active picture |
| sync_in | input | 1 | High inside the sync region |
| pattern_en | input | 1 | Replace video with the flat test field |
| luma_lo | input | 8 | Luma low clip limit |
| luma_hi | input | 8 | Luma high clip limit |
| chroma_lo | input | 8 | Chroma low clip limit |
| chroma_hi | input | 8 | Chroma high clip limit |
| luma_blank | input | 8 | Luma blanking level |
| chroma_blank | input | 8 | Chroma blanking level |
| luma_sync | input | 8 | Luma sync word |
| chroma_sync | input | 8 | Chroma sync word |
| luma_pat | input | 8 | Luma test-field value |
| chroma_pat | input | 8 | Chroma test-field value |
| luma_edge_len | input | 5 | Luma transition length in samples |
| chroma_edge_len | input | 4 | Chroma transition length in pairs |
| luma_out | output | 8 | Processed luma |
| chroma_out | output | 8 | Processed chroma |

## Verification
A corrupted position counter changes the blend weight, and the error reaches the output one clock later. It then persists for up to the edge length, so each edge step of a transition is compared sample by sample. A chroma pair phase off by one moves the chroma fade by one sample against the luma fade, which alternating chroma values show at once. Clip and ordering faults appear as outputs beyond the limit-and-blank envelope on the very next sample. Reset faults appear as nonzero outputs during reset.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    localparam int SAMPLE_W = 8;
    localparam int WEIGHT_W = 8;
    localparam int W_SHIFT  = 7;
    localparam int W_RND    = 1 << (W_SHIFT - 1);
    localparam int PHASES   = 16;
    localparam int PH_W     = $clog2(PHASES + 1);
    localparam int NCH      = 2;
    localparam int CH_LUMA  = 0;
    localparam logic [WEIGHT_W-1:0] W_FULL = WEIGHT_W'(1 << W_SHIFT);

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t lo;
        sample_t hi;
        sample_t blank;
        sample_t syncw;
        sample_t pat;
    } chan_cfg_t;

    typedef enum logic {
        OUT_MIX  = 1'b0,
        OUT_SYNC = 1'b1
    } out_sel_t;

    // Raised-cosine weight over 16 phase steps, scaled so 128 means full video.
    function automatic logic [WEIGHT_W-1:0] cos_weight(input logic [PH_W-1:0] ph);
        logic [WEIGHT_W-1:0] w;
        case (ph)
            5'd0:    w = 8'd0;
            5'd1:    w = 8'd1;
            5'd2:    w = 8'd5;
            5'd3:    w = 8'd11;
            5'd4:    w = 8'd19;
            5'd5:    w = 8'd28;
            5'd6:    w = 8'd40;
            5'd7:    w = 8'd52;
            5'd8:    w = 8'd64;
            5'd9:    w = 8'd76;
            5'd10:   w = 8'd88;
            5'd11:   w = 8'd100;
            5'd12:   w = 8'd109;
            5'd13:   w = 8'd117;
            5'd14:   w = 8'd123;
            5'd15:   w = 8'd127;
            default: w = W_FULL;
        endcase
        return w;
    endfunction

    // Lower bound first, then upper bound; the upper bound wins on conflict.
    function automatic sample_t clip_sample(input sample_t v, input sample_t lo, input sample_t hi);
        sample_t r;
        r = (v < lo) ? lo : v;
        r = (r > hi) ? hi : r;
        return r;
    endfunction

    // base + round((vid - base) * w / 128), rounding via floor after +64.
    function automatic sample_t blend(input sample_t base, input sample_t vid,
                                      input logic [WEIGHT_W-1:0] w);
        logic signed [SAMPLE_W+1:0]          diff;
        logic signed [SAMPLE_W+WEIGHT_W+2:0] prod;
        int                                  step;
        diff = $signed({2'b00, vid}) - $signed({2'b00, base});
        prod = diff * $signed({1'b0, w});
        step = (int'(prod) + W_RND) >>> W_SHIFT;
        return sample_t'(int'(base) + step);
    endfunction

endpackage

// File: rtl/vbc_edge_shaper.sv
module vbc_edge_shaper
    import vbc_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    localparam int POS_W  = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    input  logic                active,
    input  logic [LEN_W-1:0]    len_in,
    output logic [WEIGHT_W-1:0] weight
);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] len_eff;
    logic [POS_W-1:0] cur;
    logic [POS_W-1:0] nxt;
    logic [POS_W-1:0] pos_sel;
    logic [PH_W-1:0]  ph_tab [MAX_LEN+1][MAX_LEN+1];

    // Constant phase map: phase = floor(pos * PHASES / len).
    for (genvar gl = 0; gl <= MAX_LEN; gl++) begin : g_len
        for (genvar gk = 0; gk <= MAX_LEN; gk++) begin : g_pos
            if (gl == 0 || gk > gl) begin : g_unused
                assign ph_tab[gl][gk] = '0;
            end else begin : g_used
                assign ph_tab[gl][gk] = PH_W'((gk * PHASES) / gl);
            end
        end
    end

    assign len_eff = (int'(len_in) > MAX_LEN) ? POS_W'(MAX_LEN) : POS_W'(len_in);

    always_comb begin
        cur = (pos_q > len_eff) ? len_eff : pos_q;
        if (active) begin
            nxt = (cur < len_eff) ? cur + 1'b1 : cur;
        end else begin
            nxt = (cur != '0) ? cur - 1'b1 : cur;
        end
        pos_sel = adv ? nxt : cur;
        if (len_eff == '0) begin
            weight = active ? W_FULL : '0;
        end else begin
            weight = cos_weight(ph_tab[len_eff][pos_sel]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_sel;
        end
    end

    a_r5_pos_bound: assert property (@(posedge clk) disable iff (rst)
        int'(pos_q) <= MAX_LEN);

    a_r5_unit_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(len_in)) |->
            (pos_q == $past(pos_q) || pos_q == $past(pos_q) + 1'b1 || pos_q + 1'b1 == $past(pos_q)));

endmodule

// File: rtl/vbc_channel.sv
module vbc_channel
    import vbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  sample_t             vid_in,
    input  logic                sync_in,
    input  logic                pat_en,
    input  chan_cfg_t           cfg,
    input  logic [WEIGHT_W-1:0] weight,
    output sample_t             out_q
);

    sample_t  src;
    sample_t  clipped;
    sample_t  mixed;
    sample_t  out_d;
    sample_t  env_lo;
    sample_t  env_hi;
    out_sel_t sel;

    always_comb begin
        src     = pat_en ? cfg.pat : vid_in;
        clipped = clip_sample(src, cfg.lo, cfg.hi);
        mixed   = blend(cfg.blank, clipped, weight);
        sel     = sync_in ? OUT_SYNC : OUT_MIX;
        case (sel)
            OUT_SYNC: out_d = cfg.syncw;
            default:  out_d = mixed;
        endcase
        env_lo = (cfg.blank < cfg.lo) ? cfg.blank : cfg.lo;
        env_hi = (cfg.blank > cfg.hi) ? cfg.blank : cfg.hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    a_r3_sync_word: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sync_in)) |-> out_q == $past(cfg.syncw));

    a_r2_blank_level: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sync_in) && $past(weight) == '0) |-> out_q == $past(cfg.blank));

    a_r8_envelope: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sync_in) && $past(cfg.lo <= cfg.hi)) |->
            (out_q >= $past(env_lo) && out_q <= $past(env_hi)));

    a_r10_reset_out: assert property (@(posedge clk)
        $past(rst) |-> out_q == '0);

endmodule

// File: rtl/vid_blank_clip.sv
module vid_blank_clip
    import vbc_pkg::*;
#(
    parameter int Y_MAX_LEN = 16,
    parameter int C_MAX_LEN = 8,
    localparam int YLW   = $clog2(Y_MAX_LEN + 1),
    localparam int CLW   = $clog2(C_MAX_LEN + 1),
    localparam int LEN_W = (YLW > CLW) ? YLW : CLW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [7:0]     luma_in,
    input  logic [7:0]     chroma_in,
    input  logic           active_in,
    input  logic           sync_in,
    input  logic           pattern_en,
    input  logic [7:0]     luma_lo,
    input  logic [7:0]     luma_hi,
    input  logic [7:0]     chroma_lo,
    input  logic [7:0]     chroma_hi,
    input  logic [7:0]     luma_blank,
    input  logic [7:0]     chroma_blank,
    input  logic [7:0]     luma_sync,
    input  logic [7:0]     chroma_sync,
    input  logic [7:0]     luma_pat,
    input  logic [7:0]     chroma_pat,
    input  logic [YLW-1:0] luma_edge_len,
    input  logic [CLW-1:0] chroma_edge_len,
    output logic [7:0]     luma_out,
    output logic [7:0]     chroma_out
);

    logic                pair_first_q;
    sample_t             vid_a    [NCH];
    chan_cfg_t           cfg_a    [NCH];
    logic [LEN_W-1:0]    len_a    [NCH];
    logic                adv_a    [NCH];
    logic [WEIGHT_W-1:0] weight_a [NCH];
    sample_t             out_a    [NCH];

    // Chroma pair phase: high on the first sample of each pair.
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_first_q <= 1'b1;
        end else begin
            pair_first_q <= ~pair_first_q;
        end
    end

    assign vid_a[0] = luma_in;
    assign vid_a[1] = chroma_in;
    assign cfg_a[0] = '{lo: luma_lo, hi: luma_hi, blank: luma_blank,
                        syncw: luma_sync, pat: luma_pat};
    assign cfg_a[1] = '{lo: chroma_lo, hi: chroma_hi, blank: chroma_blank,
                        syncw: chroma_sync, pat: chroma_pat};
    assign len_a[0] = LEN_W'(luma_edge_len);
    assign len_a[1] = LEN_W'(chroma_edge_len);
    assign adv_a[0] = 1'b1;
    assign adv_a[1] = pair_first_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int MAXL = (g == CH_LUMA) ? Y_MAX_LEN : C_MAX_LEN;

        vbc_edge_shaper #(
            .MAX_LEN (MAXL),
            .LEN_W   (LEN_W)
        ) edge_i (
            .clk    (clk),
            .rst    (rst),
            .adv    (adv_a[g]),
            .active (active_in),
            .len_in (len_a[g]),
            .weight (weight_a[g])
        );

        vbc_channel chan_i (
            .clk     (clk),
            .rst     (rst),
            .vid_in  (vid_a[g]),
            .sync_in (sync_in),
            .pat_en  (pattern_en),
            .cfg     (cfg_a[g]),
            .weight  (weight_a[g]),
            .out_q   (out_a[g])
        );
    end

    assign luma_out   = out_a[0];
    assign chroma_out = out_a[1];

    a_r6_pair_toggle: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pair_first_q != $past(pair_first_q));

endmodule

// File: tb/vid_blank_clip_tb.sv
`timescale 1ns/1ps
module vid_blank_clip_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] y_in = '0, c_in = '0;
    logic       act = 1'b0, syn = 1'b0, pat_en = 1'b0;
    logic [7:0] ylo, yhi, clo, chi, yblk, cblk, ysyn, csyn, ypat, cpat;
    logic [4:0] ylen;
    logic [3:0] clen;
    logic [7:0] y_out, c_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_yp, m_cp;
    bit m_first;

    always #4 clk = ~clk;

    vid_blank_clip dut_i (
        .clk(clk), .rst(rst), .luma_in(y_in), .chroma_in(c_in),
        .active_in(act), .sync_in(syn), .pattern_en(pat_en),
        .luma_lo(ylo), .luma_hi(yhi), .chroma_lo(clo), .chroma_hi(chi),
        .luma_blank(yblk), .chroma_blank(cblk), .luma_sync(ysyn), .chroma_sync(csyn),
        .luma_pat(ypat), .chroma_pat(cpat), .luma_edge_len(ylen), .chroma_edge_len(clen),
        .luma_out(y_out), .chroma_out(c_out)
    );

    // {y, c, active, sync, expected y, expected c}; luma len 4, chroma len 2.
    localparam logic [33:0] VEC [17] = '{
        {8'd100, 8'd200, 1'b0, 1'b0, 8'd16,  8'd128},
        {8'd100, 8'd200, 1'b0, 1'b1, 8'd4,   8'd60 },
        {8'd100, 8'd200, 1'b0, 1'b0, 8'd16,  8'd128},
        {8'd100, 8'd200, 1'b0, 1'b0, 8'd16,  8'd128},
        {8'd200, 8'd200, 1'b1, 1'b0, 8'd43,  8'd164},
        {8'd200, 8'd40,  1'b1, 1'b0, 8'd108, 8'd84 },
        {8'd250, 8'd250, 1'b1, 1'b0, 8'd202, 8'd240},
        {8'd5,   8'd0,   1'b1, 1'b0, 8'd16,  8'd16 },
        {8'd120, 8'd128, 1'b1, 1'b0, 8'd120, 8'd128},
        {8'd120, 8'd200, 1'b0, 1'b0, 8'd105, 8'd200},
        {8'd120, 8'd200, 1'b0, 1'b0, 8'd68,  8'd164},
        {8'd120, 8'd200, 1'b0, 1'b0, 8'd31,  8'd164},
        {8'd120, 8'd200, 1'b0, 1'b0, 8'd16,  8'd128},
        {8'd120, 8'd200, 1'b0, 1'b1, 8'd4,   8'd60 },
        {8'd200, 8'd200, 1'b1, 1'b1, 8'd4,   8'd60 },
        {8'd200, 8'd200, 1'b1, 1'b0, 8'd108, 8'd164},
        {8'd200, 8'd200, 1'b0, 1'b0, 8'd43,  8'd128}
    };

    function automatic int tab_w(input int p);
        case (p)
            0: return 0;    1: return 1;    2: return 5;    3: return 11;
            4: return 19;   5: return 28;   6: return 40;   7: return 52;
            8: return 64;   9: return 76;   10: return 88;  11: return 100;
            12: return 109; 13: return 117; 14: return 123; 15: return 127;
            default: return 128;
        endcase
    endfunction

    function automatic int clipm(input int v, input int lo, input int hi);
        int r;
        r = (v < lo) ? lo : v;
        return (r > hi) ? hi : r;
    endfunction

    function automatic int mixm(input int b, input int v, input int w);
        return b + (((v - b) * w + 64) >>> 7);
    endfunction

    function automatic int next_pos(input int pos, input int len, input bit a, input bit adv);
        int cur;
        cur = (pos > len) ? len : pos;
        if (!adv) return cur;
        if (a) return (cur < len) ? cur + 1 : cur;
        return (cur > 0) ? cur - 1 : 0;
    endfunction

    function automatic int weight_of(input int pos, input int len, input bit a);
        if (len == 0) return a ? 128 : 0;
        return tab_w((pos * 16) / len);
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Called at a falling edge; drives one sample and checks its result one clock later.
    task automatic step(input int y, input int c, input bit a, input bit s,
                        input string tag, input bit hand, input int hy, input int hc);
        int yl, cl, yw, cw, ey, ec;
        y_in = 8'(y); c_in = 8'(c); act = a; syn = s;
        yl = (int'(ylen) > 16) ? 16 : int'(ylen);
        cl = (int'(clen) > 8) ? 8 : int'(clen);
        m_yp = next_pos(m_yp, yl, a, 1'b1);
        m_cp = next_pos(m_cp, cl, a, m_first);
        m_first = !m_first;
        yw = weight_of(m_yp, yl, a);
        cw = weight_of(m_cp, cl, a);
        ey = s ? int'(ysyn) : mixm(int'(yblk), clipm(pat_en ? int'(ypat) : y, int'(ylo), int'(yhi)), yw);
        ec = s ? int'(csyn) : mixm(int'(cblk), clipm(pat_en ? int'(cpat) : c, int'(clo), int'(chi)), cw);
        if (hand) begin
            ey = hy;
            ec = hc;
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " luma"}, int'(y_out), ey);
        chk({tag, " chroma"}, int'(c_out), ec);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        y_in = '0; c_in = '0; act = 1'b0; syn = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 reset luma", int'(y_out), 0);
        chk("R10 reset chroma", int'(c_out), 0);
        rst = 1'b0;
        m_yp = 0; m_cp = 0; m_first = 1'b1;
    endtask

    task automatic base_cfg();
        ylo = 8'd16; yhi = 8'd235; clo = 8'd16; chi = 8'd240;
        yblk = 8'd16; cblk = 8'd128; ysyn = 8'd4; csyn = 8'd60;
        ypat = 8'd180; cpat = 8'd90; pat_en = 1'b0;
        ylen = 5'd4; clen = 4'd2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        base_cfg();
        @(negedge clk);
        do_reset();

        // Vector table: R2 blanking, R3 sync priority, R4 weights, R6 pair reuse, R1 clip
        for (int i = 0; i < 17; i++) begin
            step(int'(VEC[i][33:26]), int'(VEC[i][25:18]), VEC[i][17], VEC[i][16],
                 $sformatf("R4 vector %0d", i), 1'b1, int'(VEC[i][15:8]), int'(VEC[i][7:0]));
        end

        // R5 and R6 at the maximum lengths; R8 envelope via values above the high limit
        base_cfg(); ylen = 5'd16; clen = 4'd8;
        do_reset();
        for (int i = 0; i < 20; i++) step(60 + i * 10, 250 - i * 11, 1'b1, 1'b0, "R5 R8 long rise", 1'b0, 0, 0);
        for (int i = 0; i < 20; i++) step(250 - i * 5, 20 + i * 9, 1'b0, 1'b0, "R6 R8 long fall", 1'b0, 0, 0);

        // R5 and R6 length clamp: 31 acts as 16, 15 acts as 8
        base_cfg(); ylen = 5'd31; clen = 4'd15;
        do_reset();
        step(144, 240, 1'b1, 1'b0, "R5 R6 clamp first", 1'b1, 17, 132);
        for (int i = 0; i < 18; i++) step(200, 40 + i * 7, 1'b1, 1'b0, "R5 R6 clamp rise", 1'b0, 0, 0);
        for (int i = 0; i < 18; i++) step(200, 230, 1'b0, 1'b0, "R5 R6 clamp fall", 1'b0, 0, 0);

        // R7 abrupt switch with zero length
        base_cfg(); ylen = 5'd0; clen = 4'd0;
        do_reset();
        step(100, 50, 1'b1, 1'b0, "R7 abrupt on", 1'b1, 100, 50);
        step(100, 50, 1'b1, 1'b0, "R7 steady", 1'b1, 100, 50);
        step(100, 50, 1'b0, 1'b0, "R7 abrupt off", 1'b1, 16, 128);

        // R9 test field replaces video, blanking and sync unchanged
        pat_en = 1'b1;
        step(30, 30, 1'b1, 1'b0, "R9 pattern active", 1'b1, 180, 90);
        step(30, 30, 1'b0, 1'b0, "R9 pattern blank", 1'b1, 16, 128);
        step(30, 30, 1'b0, 1'b1, "R9 pattern sync", 1'b1, 4, 60);
        ypat = 8'd250;
        step(30, 30, 1'b1, 1'b0, "R9 R1 pattern clipped", 1'b1, 235, 90);
        pat_en = 1'b0;

        // R1 conflicting limits: high limit wins
        ylo = 8'd200; yhi = 8'd100; clo = 8'd150; chi = 8'd140;
        step(50, 10, 1'b1, 1'b0, "R1 lo above hi low input", 1'b1, 100, 140);
        step(250, 250, 1'b1, 1'b0, "R1 lo above hi high input", 1'b1, 100, 140);

        // R10 reset mid-stream, then R2 blank level right after
        base_cfg();
        step(200, 200, 1'b1, 1'b0, "R2 pre-reset", 1'b0, 0, 0);
        do_reset();
        step(200, 200, 1'b0, 1'b0, "R2 after reset", 1'b1, 16, 128);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule